// File: doc/BRIEF.md
# Twin-Predicated Vector Element Sequencer

This block steps through the elements of one vector instruction. Once started, it issues at most one element operation per cycle. Each operation carries a source element index, a destination element index and a write enable. The element positions come from two masks, one for the source and one for the destination. Each side has its own step counter. Every operation pairs the next enabled source element with the next enabled destination element. The source side therefore compresses and the destination side expands.

Either side can be marked scalar. A scalar destination ends the loop after one operation. A scalar source reuses one index for the whole loop. A shared-predicate input applies the source mask to both sides. The loop can begin from non-zero steps, which lets an interrupted instruction resume. A stall input freezes the loop. An interrupt request lets the current element issue, then parks the loop with the step counters visible for saving. When the loop completes, both counters return to zero.

Top module: `vec_elem_seq`

## Requirements
- R1: A start with vector length zero raises `done_o` in the start cycle, issues no operation and leaves the block idle.
- R2: Each running, unstalled cycle issues one operation. The operation reads the lowest enabled source index at or above the source step and writes the lowest enabled destination index at or above the destination step, both below the vector length. With full masks of length 3, the pairs are (0,0), (1,1), (2,2).
- R3: A zero mask bit skips that element (bit i of a mask is element i). A skipped destination index never appears with `op_wen_o` high. Source mask 0b101 with a full destination mask gives (0,0), (2,1). Destination mask 0b101 with a full source mask gives (0,0), (1,2).
- R4: The loop ends when either side has no enabled element left below the vector length. `done_o` is high in the cycle of the final operation and in no other running cycle.
- R5: With `dst_scalar_i` set, exactly one operation issues and `done_o` accompanies it.
- R6: With `src_scalar_i` set, the source mask is ignored and every operation carries the starting source step as its source index, while the destination advances.
- R7: The loop may start from non-zero steps, and mask bits below a step are ignored. Length 4, source step 1, source mask 0b0101, destination step 2, destination mask 0b1010 gives the single pair (2,3).
- R8: With `shared_pred_i` set, the source mask governs both sides and `dst_mask_i` is ignored.
- R9: An all-zero mask writes nothing, and `done_o` rises in the start cycle.
- R10: After the loop completes, both saved step outputs read zero.
- R11: While `stall_i` is high, no operation issues and the step counters hold.
- R12: With `irq_i` high on a non-final operation, that operation issues with `intr_ack_o` high. The block then goes idle, and the saved steps point one past the issued source and destination indices. A restart from those steps finishes the remaining elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a loop (ignored while busy) |
| vlen_i | input | CW | Vector length, 0..MAXVL |
| src_step_i | input | CW | Starting source step |
| dst_step_i | input | CW | Starting destination step |
| src_mask_i | input | MAXVL | Source predicate, bit i = element i |
| dst_mask_i | input | MAXVL | Destination predicate, bit i = element i |
| shared_pred_i | input | 1 | Use the source mask for both sides |
| src_scalar_i | input | 1 | Source operand is scalar |
| dst_scalar_i | input | 1 | Destination operand is scalar |
| stall_i | input | 1 | Hold the loop this cycle |
| irq_i | input | 1 | Stop after the current element |
| busy_o | output | 1 | Loop in progress |
| op_valid_o | output | 1 | An element operation issues this cycle |
| op_src_idx_o | output | IW | Source element index |
| op_dst_idx_o | output | IW | Destination element index |
| op_wen_o | output | 1 | Destination write enable |
| done_o | output | 1 | Loop completes this cycle |
| intr_ack_o | output | 1 | Loop parked by the interrupt request |
| saved_src_step_o | output | CW | Source step counter |
| saved_dst_step_o | output | CW | Destination step counter |

## Verification
The pairing function is driven with full masks and with a sparse source mask only, a sparse destination mask only, and sparse masks on both sides. Each of these yields a different list of index pairs, so an error in either side's search, or a mix-up between the sides, shows up as a mismatch. Non-zero starting steps check that mask bits below a step are ignored. Shared and all-zero masks, and the scalar flags, check how the loop ends early. Stall and interrupt runs compare the issued pairs and the saved steps across a pause and a resume.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;
endpackage

// File: rtl/vseq_find.sv
// Finds the lowest set mask bit inside the window [from, limit).
module vseq_find #(
   parameter int N  = 64,
   parameter int CW = 7,
   parameter int IW = 6
) (
   input  logic [N-1:0]  mask,
   input  logic [CW-1:0] from,
   input  logic [CW-1:0] limit,
   output logic          found,
   output logic [IW-1:0] idx
);
   if (N < 2) begin : g_bad_n
      $error("vseq_find: N must be at least 2");
   end

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (mask[i] && (CW'(i) >= from) && (CW'(i) < limit)) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/vseq_state.sv
// Loop context registers: run state, step counters and latched operands.
module vseq_state
   import vseq_pkg::*;
#(
   parameter int MAXVL = 64,
   parameter int CW    = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CW-1:0]    ld_vl,
   input  logic [CW-1:0]    ld_ss,
   input  logic [CW-1:0]    ld_ds,
   input  logic [MAXVL-1:0] ld_smask,
   input  logic [MAXVL-1:0] ld_dmask,
   input  logic             ld_ssc,
   input  logic             ld_dsc,
   input  logic             clear,
   input  logic             advance,
   input  logic [CW-1:0]    adv_ss,
   input  logic [CW-1:0]    adv_ds,
   input  logic             finish,
   output logic             busy_q,
   output logic [CW-1:0]    vl_q,
   output logic [CW-1:0]    ss_q,
   output logic [CW-1:0]    ds_q,
   output logic [MAXVL-1:0] smask_q,
   output logic [MAXVL-1:0] dmask_q,
   output logic             ssc_q,
   output logic             dsc_q
);
   seq_state_e st_q;

   assign busy_q = (st_q == SEQ_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SEQ_IDLE;
         vl_q    <= '0;
         ss_q    <= '0;
         ds_q    <= '0;
         smask_q <= '0;
         dmask_q <= '0;
         ssc_q   <= 1'b0;
         dsc_q   <= 1'b0;
      end else begin
         if (load) begin
            st_q    <= SEQ_RUN;
            vl_q    <= ld_vl;
            ss_q    <= ld_ss;
            ds_q    <= ld_ds;
            smask_q <= ld_smask;
            dmask_q <= ld_dmask;
            ssc_q   <= ld_ssc;
            dsc_q   <= ld_dsc;
         end
         if (clear) begin
            ss_q <= '0;
            ds_q <= '0;
         end else if (advance) begin
            ss_q <= adv_ss;
            ds_q <= adv_ds;
         end
         if (finish) st_q <= SEQ_IDLE;
      end
   end

   AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !busy_q);  // R2
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (ss_q == '0 && ds_q == '0));  // R10
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
   import vseq_pkg::*;
#(
   parameter int MAXVL = 64,
   parameter int CW    = $clog2(MAXVL + 1),
   parameter int IW    = $clog2(MAXVL)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CW-1:0]    vlen_i,
   input  logic [CW-1:0]    src_step_i,
   input  logic [CW-1:0]    dst_step_i,
   input  logic [MAXVL-1:0] src_mask_i,
   input  logic [MAXVL-1:0] dst_mask_i,
   input  logic             shared_pred_i,
   input  logic             src_scalar_i,
   input  logic             dst_scalar_i,
   input  logic             stall_i,
   input  logic             irq_i,
   output logic             busy_o,
   output logic             op_valid_o,
   output logic [IW-1:0]    op_src_idx_o,
   output logic [IW-1:0]    op_dst_idx_o,
   output logic             op_wen_o,
   output logic             done_o,
   output logic             intr_ack_o,
   output logic [CW-1:0]    saved_src_step_o,
   output logic [CW-1:0]    saved_dst_step_o
);
   localparam int NFIND = 4;     // current src, current dst, next src, next dst
   localparam int F_SC  = 0;
   localparam int F_DC  = 1;
   localparam int F_SN  = 2;
   localparam int F_DN  = 3;

   if (MAXVL < 2) begin : g_bad_vl
      $error("vec_elem_seq: MAXVL must be at least 2");
   end
   if (CW < $clog2(MAXVL + 1) || IW < $clog2(MAXVL)) begin : g_bad_w
      $error("vec_elem_seq: index widths too narrow for MAXVL");
   end

   logic             busy_q, ssc_q, dsc_q;
   logic [CW-1:0]    vl_q, ss_q, ds_q;
   logic [MAXVL-1:0] smask_q, dmask_q;

   // operand view: live inputs while idle, latched context while running
   logic             idle;
   logic [CW-1:0]    cur_vl, cur_ss, cur_ds;
   logic [MAXVL-1:0] cur_smask, cur_dmask;
   logic             cur_ssc, cur_dsc;

   assign idle      = !busy_q;
   assign cur_vl    = idle ? vlen_i       : vl_q;
   assign cur_ss    = idle ? src_step_i   : ss_q;
   assign cur_ds    = idle ? dst_step_i   : ds_q;
   assign cur_smask = idle ? src_mask_i   : smask_q;
   assign cur_dmask = idle ? (shared_pred_i ? src_mask_i : dst_mask_i) : dmask_q;
   assign cur_ssc   = idle ? src_scalar_i : ssc_q;
   assign cur_dsc   = idle ? dst_scalar_i : dsc_q;

   logic [MAXVL-1:0] f_mask  [NFIND];
   logic [CW-1:0]    f_from  [NFIND];
   logic             f_found [NFIND];
   logic [IW-1:0]    f_idx   [NFIND];

   assign f_mask[F_SC] = cur_smask;
   assign f_mask[F_DC] = cur_dmask;
   assign f_mask[F_SN] = cur_smask;
   assign f_mask[F_DN] = cur_dmask;
   assign f_from[F_SC] = cur_ss;
   assign f_from[F_DC] = cur_ds;
   assign f_from[F_SN] = CW'(f_idx[F_SC]) + CW'(1);
   assign f_from[F_DN] = CW'(f_idx[F_DC]) + CW'(1);

   for (genvar g = 0; g < NFIND; g++) begin : g_find
      vseq_find #(.N(MAXVL), .CW(CW), .IW(IW)) u_find (
         .mask  (f_mask[g]),
         .from  (f_from[g]),
         .limit (cur_vl),
         .found (f_found[g]),
         .idx   (f_idx[g])
      );
   end

   logic          s_avail, d_avail, can_issue, s_more, d_more, last;
   logic          start_empty, issue;
   logic [IW-1:0] src_idx;

   assign s_avail   = cur_ssc ? (cur_ss < cur_vl) : f_found[F_SC];
   assign d_avail   = f_found[F_DC];
   assign can_issue = s_avail && d_avail;
   assign src_idx   = cur_ssc ? cur_ss[IW-1:0] : f_idx[F_SC];
   assign s_more    = cur_ssc || f_found[F_SN];
   assign d_more    = f_found[F_DN];
   assign last      = cur_dsc || !s_more || !d_more;

   assign start_empty = idle && start_i && !can_issue;
   assign issue       = busy_q && !stall_i;

   vseq_state #(.MAXVL(MAXVL), .CW(CW)) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (idle && start_i && can_issue),
      .ld_vl    (vlen_i),
      .ld_ss    (src_step_i),
      .ld_ds    (dst_step_i),
      .ld_smask (src_mask_i),
      .ld_dmask (shared_pred_i ? src_mask_i : dst_mask_i),
      .ld_ssc   (src_scalar_i),
      .ld_dsc   (dst_scalar_i),
      .clear    (start_empty || (issue && last)),
      .advance  (issue && !last),
      .adv_ss   (cur_ssc ? cur_ss : (CW'(src_idx) + CW'(1))),
      .adv_ds   (CW'(f_idx[F_DC]) + CW'(1)),
      .finish   (issue && (last || irq_i)),
      .busy_q   (busy_q),
      .vl_q     (vl_q),
      .ss_q     (ss_q),
      .ds_q     (ds_q),
      .smask_q  (smask_q),
      .dmask_q  (dmask_q),
      .ssc_q    (ssc_q),
      .dsc_q    (dsc_q)
   );

   assign busy_o           = busy_q;
   assign op_valid_o       = issue;
   assign op_wen_o         = issue;
   assign op_src_idx_o     = src_idx;
   assign op_dst_idx_o     = f_idx[F_DC];
   assign done_o           = start_empty || (issue && last);
   assign intr_ack_o       = issue && irq_i && !last;
   assign saved_src_step_o = ss_q;
   assign saved_dst_step_o = ds_q;

   AST_IDLE_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !op_valid_o);  // R2
   AST_WEN_ON_DST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      op_wen_o |-> dmask_q[op_dst_idx_o]);  // R3
   AST_SRC_ON_SRC_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_o && !ssc_q) |-> smask_q[op_src_idx_o]);  // R3
   AST_DST_AT_OR_ABOVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid_o |-> (CW'(op_dst_idx_o) >= ds_q && CW'(op_dst_idx_o) < vl_q));  // R7
   AST_SCALAR_DST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_o && dsc_q) |-> done_o);  // R5
   AST_SCALAR_SRC_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_o && ssc_q) |-> (CW'(op_src_idx_o) == ss_q));  // R6
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && stall_i) |=> ($stable(ss_q) && $stable(ds_q) && busy_q));  // R11
   AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_q);  // R4
   AST_IRQ_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
      intr_ack_o |=> !busy_q);  // R12
endmodule

// File: tb/tb_vec_elem_seq.sv
module tb_vec_elem_seq;
   localparam int CLK_PERIOD = 10;
   localparam int MAXVL = 64;
   localparam int CW = $clog2(MAXVL + 1);
   localparam int IW = $clog2(MAXVL);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [CW-1:0] vlen_i = '0, src_step_i = '0, dst_step_i = '0;
   logic [MAXVL-1:0] src_mask_i = '0, dst_mask_i = '0;
   logic shared_pred_i = 1'b0, src_scalar_i = 1'b0, dst_scalar_i = 1'b0;
   logic stall_i = 1'b0, irq_i = 1'b0;
   logic busy_o, op_valid_o, op_wen_o, done_o, intr_ack_o;
   logic [IW-1:0] op_src_idx_o, op_dst_idx_o;
   logic [CW-1:0] saved_src_step_o, saved_dst_step_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   vec_elem_seq #(.MAXVL(MAXVL)) dut (.*);

   task automatic chk(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // pairs packed as bytes, first op in bits [7:0]: {src[3:0], dst[3:0]}
   task automatic run(string req, int vl, int ss, int ds, longint sm, longint dm,
                      bit shared, bit ssc, bit dsc, int stall_at, int irq_at,
                      int exp_n, longint exp_pairs, bit exp_imm, bit exp_irq);
      int n = 0;
      longint got = 0;
      bit done_bad = 0, wen_bad = 0, stall_bad = 0, imm, ack = 0, fin = 0;
      @(negedge clk);
      vlen_i = CW'(vl); src_step_i = CW'(ss); dst_step_i = CW'(ds);
      src_mask_i = MAXVL'(sm); dst_mask_i = MAXVL'(dm);
      shared_pred_i = shared; src_scalar_i = ssc; dst_scalar_i = dsc;
      start_i = 1'b1;
      #1 imm = done_o;
      chk(req, "done in start cycle", imm, exp_imm);
      @(negedge clk);
      start_i = 1'b0;
      if (!imm) begin
         for (int cyc = 0; cyc < 20; cyc++) begin
            if (cyc > 0) @(negedge clk);
            stall_i = (cyc == stall_at);
            irq_i   = (cyc == irq_at);
            #1;
            if (stall_i && op_valid_o) stall_bad = 1;
            if (op_valid_o) begin
               if (!op_wen_o) wen_bad = 1;
               got |= longint'({op_src_idx_o[3:0], op_dst_idx_o[3:0]}) << (8 * n);
               n++;
            end
            if (intr_ack_o) begin ack = 1; break; end
            if (done_o) begin fin = 1; break; end
         end
         if (!fin && !ack) done_bad = 1;
         if (fin && n != exp_n) done_bad = 1;
         @(negedge clk);
         stall_i = 1'b0; irq_i = 1'b0;
      end
      #1;
      chk(req, "op count", n, exp_n);
      chk(req, "op pairs", got, exp_pairs);
      chk(req, "done on final op only", done_bad, 0);
      chk(req, "write enable with op", wen_bad, 0);
      chk(req, "intr ack", ack, exp_irq);
      chk(req, "busy after run", busy_o, 0);
      if (stall_at >= 0) chk("R11", "no op while stalled", stall_bad, 0);
      if (!exp_irq) begin
         chk("R10", "saved src step zero", saved_src_step_o, 0);
         chk("R10", "saved dst step zero", saved_dst_step_o, 0);
      end
   endtask

   task automatic t_reset();
      #1;
      chk("R2", "reset busy", busy_o, 0);
      chk("R2", "reset op_valid", op_valid_o, 0);
      chk("R10", "reset saved steps", {saved_src_step_o, saved_dst_step_o}, 0);
   endtask

   task automatic t_irq_resume();
      run("R12 irq park", 4, 0, 0, 'hF, 'hF, 0, 0, 0, -1, 0, 1, 'h00, 0, 1);
      chk("R12", "saved src after irq", saved_src_step_o, 1);
      chk("R12", "saved dst after irq", saved_dst_step_o, 1);
      run("R12 resume", 4, 1, 1, 'hF, 'hF, 0, 0, 0, -1, -1, 3, 'h332211, 0, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 3);
      t_reset();
      @(negedge clk); rst_n = 1'b1;
      run("R1 zero length", 0, 0, 0, 'hF, 'hF, 0, 0, 0, -1, -1, 0, 0, 1, 0);
      run("R2 full masks", 3, 0, 0, 'h7, 'h7, 0, 0, 0, -1, -1, 3, 'h221100, 0, 0);
      run("R3 compress", 3, 0, 0, 'h5, 'h7, 0, 0, 0, -1, -1, 2, 'h2100, 0, 0);
      run("R3 expand", 3, 0, 0, 'h7, 'h5, 0, 0, 0, -1, -1, 2, 'h1200, 0, 0);
      run("R4 twin masks", 3, 0, 0, 'h5, 'h2, 0, 0, 0, -1, -1, 1, 'h01, 0, 0);
      run("R7 nonzero steps", 4, 1, 2, 'h5, 'hA, 0, 0, 0, -1, -1, 1, 'h23, 0, 0);
      run("R5 scalar dest", 3, 0, 0, 'h7, 'h7, 0, 0, 1, -1, -1, 1, 'h00, 0, 0);
      run("R6 scalar src", 3, 2, 0, 'h0, 'h7, 0, 1, 0, -1, -1, 3, 'h222120, 0, 0);
      run("R8 shared pred", 3, 0, 0, 'h5, 'h7, 1, 0, 0, -1, -1, 2, 'h2200, 0, 0);
      run("R9 all zero mask", 3, 0, 0, 'h0, 'h0, 1, 0, 0, -1, -1, 0, 0, 1, 0);
      run("R11 stall", 3, 0, 0, 'h7, 'h7, 0, 0, 0, 1, -1, 3, 'h221100, 0, 0);
      t_irq_resume();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule